// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block controls thirteen general-purpose pins through a byte-wide register bus. Each pin has two bytes of its own. The drive byte sets the output level, the direction, push-pull or open-drain drive, and a pull-resistor choice. The sense byte returns the synchronized pad level and holds a two-bit code that picks which edges raise an interrupt. The pins are banked 7, 4 and 2, but the banks only matter for how the pins are packed into the interrupt bytes.

Pad inputs pass through two flops before any use. A third flop keeps the previous synchronized level, so the block can detect rising and falling edges. A detected edge that matches a pin's code sets a sticky pending bit. Pending bits live in two bytes of 7 and 6 bits and are cleared by writing 1. A matching pair of mask bytes gates them onto a single combined interrupt line. Software configures pins through the drive and sense bytes, unmasks the pins it cares about, and on an interrupt reads the pending bytes, services each pin and writes the set bits back to clear them.

Top module: `gpio_edge_ctl`

## Requirements
- R1: The drive byte of pin i is at 0x4e44+i. It stores bits 5:0, and bits 7:6 read as 0. Bit 0 drives `pad_out`, bits 2:1 drive the pin's field of `pull_sel`, bit 3 drives `pull_en`, bit 4 drives `pad_pp` (1 means push-pull) and bit 5 is the direction (1 means output).
- R2: `pad_oe` of a pin is 1 only when the direction bit is 1 and the pin is either push-pull or has an output value of 0.
- R3: The sense byte of pin i is at 0x4e51+i. Bit 0 is the pad level seen through two flops: it changes two rising clock edges after the pad changes. Bits 2:1 read back the stored edge code, and bits 7:3 read as 0.
- R4: The edge code works as follows: 00 never interrupts, 01 reacts to a falling edge, 10 to a rising edge and 11 to both. A matching edge sets the pin's pending bit on the third rising clock edge after the pad change.
- R5: Pending bits for pins 0 to 6 read at 0x4e0b in bits 6:0. Pending bits for pins 7 to 12 read at 0x4e0c in bits 5:0. The unused upper bits read as 0.
- R6: Writing a 1 to a pending bit clears it, and writing a 0 leaves it as it is. If an edge sets a bit in the same cycle that a write clears it, the bit stays set.
- R7: The mask bytes at 0x4e19 and 0x4e1a use the same pin-to-bit packing as the pending bytes. A mask bit of 1 keeps that pin off the interrupt line.
- R8: `irq` is the OR of all pending bits whose mask bit is 0.
- R9: A write to any address outside the mapped bytes, including drive or sense bytes for a pin index of 13 or more, changes nothing, and a read of such an address returns 0. `rdata` is 0 whenever `re` is low.
- R10: After reset, every drive byte and sense code is 0, every pending bit is 0, every mask bit is 1, and `irq` and `pad_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Register byte address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe, acts on the rising edge |
| re | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational from `addr` while `re` is high |
| pad_in | input | 13 | Pad levels, asynchronous |
| pad_out | output | 13 | Output value for each pin |
| pad_oe | output | 13 | Pad output enable for each pin |
| pad_pp | output | 13 | 1 means push-pull, 0 means open-drain |
| pull_en | output | 13 | Pull-resistor enable for each pin |
| pull_sel | output | 26 | Two-bit pull choice for each pin, pin i in bits 2i+1:2i |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume the following about the inputs. Each bus access is a single-cycle strobe with a stable address. The only way to lower a pending bit is a write to a pending byte in the previous cycle. The pads can change at any time relative to the bus. The stimulus changes bus signals and pads only at falling clock edges. After each pad change it waits four cycles, so the expected pending state can be worked out from the level before and after the change. One directed case times a clearing write to land exactly on the edge that sets the same bit.

// File: rtl/gpio_edge_ctl.sv
module gpio_edge_ctl #(
  parameter int NPINS = 13,
  parameter int G0 = 7,
  parameter int AW = 16,
  parameter logic [15:0] OUT_BASE = 16'h4e44,
  parameter logic [15:0] IN_BASE  = 16'h4e51,
  parameter logic [15:0] STS_BASE = 16'h4e0b,
  parameter logic [15:0] MSK_BASE = 16'h4e19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic [7:0]           wdata,
  input  logic                 we,
  input  logic                 re,
  output logic [7:0]           rdata,
  input  logic [NPINS-1:0]     pad_in,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_pp,
  output logic [NPINS-1:0]     pull_en,
  output logic [2*NPINS-1:0]   pull_sel,
  output logic                 irq
);
  localparam int G1 = NPINS - G0;
  localparam int PW = $clog2(NPINS);
  localparam logic [AW-1:0] NP = AW'(NPINS);

  logic [5:0] octl [NPINS];
  logic [1:0] edg  [NPINS];
  logic [NPINS-1:0] s1, s2, s3, sts, msk, hit, clr;

  logic [AW-1:0] ooff, ioff;
  logic [PW-1:0] opin, ipin;
  logic o_hit, i_hit, sg0, sg1, mg0, mg1;

  assign ooff  = addr - AW'(OUT_BASE);
  assign ioff  = addr - AW'(IN_BASE);
  assign o_hit = ooff < NP;
  assign i_hit = ioff < NP;
  assign opin  = ooff[PW-1:0];
  assign ipin  = ioff[PW-1:0];
  assign sg0   = addr == AW'(STS_BASE);
  assign sg1   = addr == AW'(STS_BASE + 16'd1);
  assign mg0   = addr == AW'(MSK_BASE);
  assign mg1   = addr == AW'(MSK_BASE + 16'd1);

  assign clr = we ? {{G1{sg1}} & wdata[G1-1:0], {G0{sg0}} & wdata[G0-1:0]} : '0;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign hit[i]          = (edg[i][1] & s2[i] & ~s3[i]) | (edg[i][0] & ~s2[i] & s3[i]);
    assign pad_out[i]      = octl[i][0];
    assign pull_sel[2*i+:2] = octl[i][2:1];
    assign pull_en[i]      = octl[i][3];
    assign pad_pp[i]       = octl[i][4];
    assign pad_oe[i]       = octl[i][5] & (octl[i][4] | ~octl[i][0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= '0;
      s2  <= '0;
      s3  <= '0;
      sts <= '0;
      msk <= '1;
      for (int i = 0; i < NPINS; i++) begin
        octl[i] <= '0;
        edg[i]  <= '0;
      end
    end else begin
      s1  <= pad_in;
      s2  <= s1;
      s3  <= s2;
      sts <= (sts & ~clr) | hit;
      if (we && mg0) msk[G0-1:0]     <= wdata[G0-1:0];
      if (we && mg1) msk[NPINS-1:G0] <= wdata[G1-1:0];
      for (int i = 0; i < NPINS; i++) begin
        if (we && o_hit && opin == PW'(i)) octl[i] <= wdata[5:0];
        if (we && i_hit && ipin == PW'(i)) edg[i]  <= wdata[2:1];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (re) begin
      if (o_hit)    rdata = {2'b00, octl[opin]};
      else if (i_hit) rdata = {5'b00000, edg[ipin], s2[ipin]};
      else if (sg0) rdata = 8'(sts[G0-1:0]);
      else if (sg1) rdata = 8'(sts[NPINS-1:G0]);
      else if (mg0) rdata = 8'(msk[G0-1:0]);
      else if (mg1) rdata = 8'(msk[NPINS-1:G0]);
    end
  end

  assign irq = |(sts & ~msk);

  logic unused_bits;
  assign unused_bits = &{1'b0, wdata[7]};
endmodule

// File: rtl/gpio_edge_ctl_chk.sv
module gpio_edge_ctl_chk #(
  parameter int NPINS = 13,
  parameter int AW = 16,
  parameter logic [15:0] STS_BASE = 16'h4e0b
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             we,
  input logic             re,
  input logic [7:0]       rdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_pp,
  input logic [NPINS-1:0] sts,
  input logic [NPINS-1:0] msk,
  input logic             irq
);
  AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~pad_pp & pad_out) == '0); // R2

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !re |-> rdata == 8'h00); // R9

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk) |-> !irq); // R7

  AST_IRQ_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != '0)); // R8

  AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(sts) & ~sts) != '0) |-> ($past(we) &&
      ($past(addr) == AW'(STS_BASE) || $past(addr) == AW'(STS_BASE + 16'd1))))); // R6
endmodule

bind gpio_edge_ctl gpio_edge_ctl_chk #(.NPINS(NPINS), .AW(AW), .STS_BASE(STS_BASE)) u_chk (.*);

// File: tb/gpio_edge_ctl_tb.sv
module gpio_edge_ctl_tb;
  localparam int CLK_NS = 10;
  localparam int NP = 13;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [NP-1:0] pad_in = '0;
  wire [7:0] rdata;
  wire [NP-1:0] pad_out, pad_oe, pad_pp, pull_en;
  wire [2*NP-1:0] pull_sel;
  wire irq;

  gpio_edge_ctl u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pp(pad_pp),
    .pull_en(pull_en), .pull_sel(pull_sel), .irq(irq));

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [5:0] m_o [NP];
  logic [1:0] m_e [NP];
  logic [NP-1:0] m_s = '0, m_m = '1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mrd(logic [15:0] a);
    int ia = int'(a);
    if (ia >= 'h4e44 && ia < 'h4e44 + NP) return {2'b00, m_o[ia - 'h4e44]};
    if (ia >= 'h4e51 && ia < 'h4e51 + NP) return {5'b0, m_e[ia - 'h4e51], pad_in[ia - 'h4e51]};
    if (ia == 'h4e0b) return {1'b0, m_s[6:0]};
    if (ia == 'h4e0c) return {2'b0, m_s[12:7]};
    if (ia == 'h4e19) return {1'b0, m_m[6:0]};
    if (ia == 'h4e1a) return {2'b0, m_m[12:7]};
    return 8'h00;
  endfunction

  task automatic wr(logic [15:0] a, logic [7:0] d);
    int ia = int'(a);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (ia >= 'h4e44 && ia < 'h4e44 + NP) m_o[ia - 'h4e44] = d[5:0];
    if (ia >= 'h4e51 && ia < 'h4e51 + NP) m_e[ia - 'h4e51] = d[2:1];
    if (ia == 'h4e0b) m_s[6:0]  = m_s[6:0] & ~d[6:0];
    if (ia == 'h4e0c) m_s[12:7] = m_s[12:7] & ~d[5:0];
    if (ia == 'h4e19) m_m[6:0]  = d[6:0];
    if (ia == 'h4e1a) m_m[12:7] = d[5:0];
  endtask

  task automatic rd(string req, logic [15:0] a);
    addr = a; re = 1'b1;
    #1 chk(req, rdata, mrd(a));
    re = 1'b0;
  endtask

  task automatic pad(int p, logic v);
    logic old = pad_in[p];
    pad_in[p] = v;
    repeat (4) @(negedge clk);
    if (old != v && ((v && m_e[p][1]) || (!v && m_e[p][0]))) m_s[p] = 1'b1;
  endtask

  task automatic outs(string req);
    for (int i = 0; i < NP; i++) begin
      chk({req, " out"}, pad_out[i], m_o[i][0]);
      chk({req, " pull"}, {pull_en[i], pull_sel[2*i+:2]}, {m_o[i][3], m_o[i][2:1]});
      chk({req, " pp"}, pad_pp[i], m_o[i][4]);
      chk({req, " oe"}, pad_oe[i], m_o[i][5] & (m_o[i][4] | ~m_o[i][0]));
    end
  endtask

  task automatic irq_chk(string req);
    chk(req, irq, |(m_s & ~m_m));
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < NP; i++) begin m_o[i] = '0; m_e[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    rd("R10 msk0", 16'h4e19); rd("R10 msk1", 16'h4e1a);
    rd("R10 sts0", 16'h4e0b); rd("R10 drv", 16'h4e44);
    chk("R10 irq", irq, 1'b0); chk("R10 oe", pad_oe, '0);
    // R1 drive byte
    wr(16'h4e47, 8'hff); rd("R1 readback", 16'h4e47); outs("R1");
    // R2 open-drain
    wr(16'h4e44, 8'h21); chk("R2 od high", pad_oe[0], 1'b0);
    wr(16'h4e44, 8'h20); chk("R2 od low", pad_oe[0], 1'b1);
    wr(16'h4e44, 8'h31); chk("R2 pp", pad_oe[0], 1'b1);
    wr(16'h4e44, 8'h11); chk("R2 input", pad_oe[0], 1'b0);
    // R3 sync latency
    pad_in[5] = 1'b1;
    @(negedge clk); addr = 16'h4e56; re = 1'b1; #1 chk("R3 one edge", rdata[0], 1'b0); re = 1'b0;
    @(negedge clk); addr = 16'h4e56; re = 1'b1; #1 chk("R3 two edges", rdata[0], 1'b1); re = 1'b0;
    @(negedge clk);
    wr(16'h4e56, 8'hff); rd("R3 sense", 16'h4e56);
    // R4 R5 R6 R7 R8 on pin 9
    wr(16'h4e1a, 8'h00); wr(16'h4e5a, 8'h04);
    pad(9, 1'b0); rd("R4 no rise", 16'h4e0c);
    pad(9, 1'b1); rd("R4 rise", 16'h4e0c); rd("R5 g0", 16'h4e0b); irq_chk("R8 pend");
    wr(16'h4e1a, 8'h3f); irq_chk("R7 masked");
    wr(16'h4e1a, 8'h00);
    wr(16'h4e0c, 8'h00); rd("R6 w0", 16'h4e0c);
    wr(16'h4e0c, 8'h04); rd("R6 w1", 16'h4e0c); irq_chk("R8 clear");
    // R6 set wins
    wr(16'h4e53, 8'h06); pad_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    addr = 16'h4e0b; wdata = 8'h04; we = 1'b1;
    @(negedge clk); we = 1'b0; m_s[2] = 1'b1;
    rd("R6 set wins", 16'h4e0b);
    // R9 unmapped
    wr(16'h4e5e, 8'hff); wr(16'h4e43, 8'hff); wr(16'h4e0d, 8'hff);
    rd("R9 pin13", 16'h4e5e); rd("R9 below", 16'h4e43); rd("R9 sts2", 16'h4e0d);
    rd("R9 sts0 kept", 16'h4e0b); outs("R9");
    addr = 16'h4e44; #1 chk("R9 idle", rdata, 8'h00);
    // random
    for (int k = 0; k < 400; k++) begin
      int p = int'($urandom_range(NP - 1));
      case ($urandom_range(5))
        0: wr(16'(16'h4e44 + p), 8'($urandom));
        1: wr(16'(16'h4e51 + p), 8'($urandom));
        2: wr(($urandom_range(1) != 0) ? 16'h4e1a : 16'h4e19, 8'($urandom));
        3: wr(($urandom_range(1) != 0) ? 16'h4e0c : 16'h4e0b, 8'($urandom));
        default: pad(p, ~pad_in[p]);
      endcase
      rd("R4 R5 rand", 16'(($urandom_range(1) != 0) ? 16'h4e0b : 16'h4e0c));
      rd("R1 R3 rand", 16'(16'h4e44 + $urandom_range(2*NP)));
      irq_chk("R8 rand");
    end
    outs("R2 rand");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule